// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block carries out the multi-cycle part of a compact 16-bit save or restore instruction. The decoder gives it the fields of one instruction: direction, a three-bit link mask for the return-address register and the two callee-saved registers r16/r17, an extra-register count, a four-bit argument code and the frame-size fields. The sequencer reads the stack pointer (r29) through the register-file read port. It then walks its register list in a fixed order and issues one word transfer per accepted memory beat. At the end it writes the new stack pointer back through the register-file write port.

A save first stores the incoming argument registers above the stack pointer, at increasing offsets. Every other store goes below the stack pointer, and the running pointer drops by four before each of them. A restore starts its running pointer one frame above the current stack pointer. It reloads the same registers in the same order, leaves the incoming arguments alone and then sets the stack pointer to the top of the frame. The short form of the instruction carries no prefix. For it, the extra-register count and the argument code count as zero.

Top module: `frame_seq`

## Requirements
- R1: Frame size in bytes. In the short form, a `frame_lo` of 0 gives 128 and any other value gives `frame_lo`×8. In the extended form the size is {`frame_hi`,`frame_lo`}×8, so 0 gives 0.
- R2: In the extended form the argument code sets two counts. Incoming arguments: 0 for codes 0–3 and 11, 1 for 4–7, 2 for 8–10, 3 for 12–13, 4 for 14. Statics: 0 for codes 0, 4, 8, 12 and 14, 1 for 1, 5, 9 and 13, 2 for 2, 6 and 10, 3 for 3 and 7, 4 for 11.
- R3: A save stores incoming argument k (k = 0..count-1), which is register r(4+k), at address sp+4k. These stores come first and leave the running pointer unchanged.
- R4: Each save store after the arguments goes to the running pointer minus 4, and the running pointer starts at sp. The order is fixed: r31 when `link_mask[2]` is set; r30 when the extra count is 7; r(17+n) down to r18, where n is the extra count capped at 6; r17 when `link_mask[0]` is set; r16 when `link_mask[1]` is set; then r7 downward for the static count.
- R5: A save ends by writing sp − frame size into r29.
- R6: A restore issues loads in the R4 order, with the running pointer starting at sp + frame size. It never loads the incoming-argument registers.
- R7: Each loaded word is written to its register the cycle after the load is accepted, sign-extended to the register width. With 32-bit registers this is the word itself. The restore ends by writing sp + frame size into r29.
- R8: An extended-form start with argument code 15 pulses `err` for one cycle, starting the cycle after `start`. It makes no transfer and leaves r29 unchanged. The short form ignores `extra_cnt` and `arg_code`.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: `busy` is high from the cycle after an accepted `start` until the r29 write. `done` pulses for one cycle right after that write, even when the register list is empty.
- R11: After reset the block is idle: `busy`, `done`, `err`, `mem_valid` and `rf_we` are all low.
- R12: While `mem_valid` is high and `mem_ready` is low, the request stays asserted with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one instruction (taken only when idle) |
| op_save | input | 1 | 1 = save, 0 = restore |
| op_ext | input | 1 | 1 = extended form with prefix fields |
| link_mask | input | 3 | bit2 r31, bit1 r16, bit0 r17 |
| extra_cnt | input | 3 | Extra saved-register count (extended only) |
| arg_code | input | 4 | Argument/static code (extended only) |
| frame_lo | input | 4 | Low frame-size field |
| frame_hi | input | 4 | High frame-size field (extended only) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-code pulse |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid the cycle after acceptance |

## Verification
The bench uses the full register list, with an extra count of 7, to confirm that r30 comes before r23. A design that counted from r18 upward, or left out r30, would put every later word at the wrong address. Argument codes 14, 11 and 6 each split differently into arguments and statics. A swapped decode table would make stores above sp where none belong, or reload argument registers on restore, and the argument registers are clobbered beforehand so that such a reload shows up. A zero extended frame field and an empty short-form list check that the frame arithmetic does not treat 0 as 128 and that `done` still arrives. Random memory stalls, code 15 and a second `start` pulsed mid-run check for lost or duplicated beats, transfers on an illegal code and a restart while busy.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int REG_AW     = 5;
    localparam int NSLOT      = 18;
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int FRAME_W    = 12;
    localparam int NARGSLOT   = 4;
    localparam logic [REG_AW-1:0] SP_REG = REG_AW'(29);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SP,
        ST_XFER,
        ST_LOAD,
        ST_SPWR
    } seq_state_e;

    typedef struct packed {
        logic [NSLOT-1:0]   en;
        logic [FRAME_W-1:0] frame;
        logic               bad;
    } plan_t;

    // incoming-argument count for an argument code
    function automatic int unsigned incoming_count(input logic [3:0] code);
        unique case (code)
            4'd4, 4'd5, 4'd6, 4'd7: return 1;
            4'd8, 4'd9, 4'd10:      return 2;
            4'd12, 4'd13:           return 3;
            4'd14:                  return 4;
            default:                return 0;
        endcase
    endfunction

    // static-register count for an argument code
    function automatic int unsigned static_count(input logic [3:0] code);
        unique case (code)
            4'd1, 4'd5, 4'd9, 4'd13: return 1;
            4'd2, 4'd6, 4'd10:       return 2;
            4'd3, 4'd7:              return 3;
            4'd11:                   return 4;
            default:                 return 0;
        endcase
    endfunction

    // slot order: 0..3 args r4..r7, 4 r31, 5 r30, 6..11 r23..r18,
    // 12 r17, 13 r16, 14..17 statics r7..r4
    function automatic logic [REG_AW-1:0] slot_reg(input logic [SLOT_W-1:0] s);
        if (s < 5'd4)       return REG_AW'(4 + int'(s));
        else if (s == 5'd4) return REG_AW'(31);
        else if (s == 5'd5) return REG_AW'(30);
        else if (s < 5'd12) return REG_AW'(23 - (int'(s) - 6));
        else if (s == 5'd12) return REG_AW'(17);
        else if (s == 5'd13) return REG_AW'(16);
        else                return REG_AW'(7 - (int'(s) - 14));
    endfunction

    function automatic logic slot_is_arg(input logic [SLOT_W-1:0] s);
        return s < SLOT_W'(NARGSLOT);
    endfunction

    // a loaded word widened to the register width (identity at 32 bits)
    function automatic logic [WORD_W-1:0] load_extend(input logic [31:0] w);
        return WORD_W'($signed(w));
    endfunction

endpackage

// File: rtl/frame_seq_plan.sv
module frame_seq_plan
    import frame_seq_pkg::*;
(
    input  logic       op_save,
    input  logic       op_ext,
    input  logic [2:0] link_mask,
    input  logic [2:0] extra_cnt,
    input  logic [3:0] arg_code,
    input  logic [3:0] frame_lo,
    input  logic [3:0] frame_hi,
    output plan_t      plan
);
    int unsigned n_in;
    int unsigned n_st;
    int unsigned n_x;

    always_comb begin
        n_in = op_ext ? incoming_count(arg_code) : 0;
        n_st = op_ext ? static_count(arg_code) : 0;
        n_x  = op_ext ? int'(extra_cnt) : 0;

        plan.en = '0;
        for (int i = 0; i < NARGSLOT; i++)
            plan.en[i] = op_save && (i < int'(n_in));
        plan.en[4] = link_mask[2];
        plan.en[5] = (n_x == 7);
        for (int j = 0; j < 6; j++)
            plan.en[6 + j] = (n_x == 7) || (j >= 6 - int'(n_x));
        plan.en[12] = link_mask[0];
        plan.en[13] = link_mask[1];
        for (int k = 0; k < NARGSLOT; k++)
            plan.en[14 + k] = k < int'(n_st);

        if (op_ext)
            plan.frame = FRAME_W'({frame_hi, frame_lo, 3'b000});
        else if (frame_lo == 4'd0)
            plan.frame = FRAME_W'(128);
        else
            plan.frame = FRAME_W'({frame_lo, 3'b000});

        plan.bad = op_ext && (arg_code == 4'd15);
    end
endmodule

// File: rtl/frame_seq_pick.sv
module frame_seq_pick
    import frame_seq_pkg::*;
(
    input  logic [NSLOT-1:0]  mask,
    output logic              any,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (mask[i]) idx = SLOT_W'(i);
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_save,
    input  logic              op_ext,
    input  logic [2:0]        link_mask,
    input  logic [2:0]        extra_cnt,
    input  logic [3:0]        arg_code,
    input  logic [3:0]        frame_lo,
    input  logic [3:0]        frame_hi,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    seq_state_e         state_q;
    plan_t              plan_d;
    logic [NSLOT-1:0]   pend_q;
    logic [FRAME_W-1:0] frame_q;
    logic               save_q;
    logic [WORD_W-1:0]  sp_q;
    logic [WORD_W-1:0]  ptr_q;
    logic [REG_AW-1:0]  load_reg_q;
    logic               done_q;
    logic               err_q;
    logic               slot_any;
    logic [SLOT_W-1:0]  slot_idx;
    logic               cur_arg;
    logic [WORD_W-1:0]  frame_w;

    frame_seq_plan u_plan (
        .op_save   (op_save),
        .op_ext    (op_ext),
        .link_mask (link_mask),
        .extra_cnt (extra_cnt),
        .arg_code  (arg_code),
        .frame_lo  (frame_lo),
        .frame_hi  (frame_hi),
        .plan      (plan_d)
    );

    frame_seq_pick u_pick (
        .mask (pend_q),
        .any  (slot_any),
        .idx  (slot_idx)
    );

    assign frame_w = WORD_W'(frame_q);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign err     = err_q;

    always_comb begin
        cur_arg   = slot_any && slot_is_arg(slot_idx);
        rf_raddr  = (state_q == ST_SP) ? SP_REG : slot_reg(slot_idx);
        mem_valid = (state_q == ST_XFER) && slot_any;
        mem_we    = mem_valid && save_q;
        mem_addr  = cur_arg ? sp_q + WORD_W'({slot_idx[1:0], 2'b00})
                            : ptr_q - WORD_W'(WORD_BYTES);
        mem_wdata = rf_rdata;
        rf_we     = 1'b0;
        rf_waddr  = load_reg_q;
        rf_wdata  = load_extend(mem_rdata[31:0]);
        if (state_q == ST_LOAD) begin
            rf_we = 1'b1;
        end else if (state_q == ST_SPWR) begin
            rf_we    = 1'b1;
            rf_waddr = SP_REG;
            rf_wdata = save_q ? sp_q - frame_w : sp_q + frame_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_q     <= '0;
            frame_q    <= '0;
            save_q     <= 1'b0;
            sp_q       <= '0;
            ptr_q      <= '0;
            load_reg_q <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (plan_d.bad) begin
                            err_q <= 1'b1;
                        end else begin
                            pend_q  <= plan_d.en;
                            frame_q <= plan_d.frame;
                            save_q  <= op_save;
                            state_q <= ST_SP;
                        end
                    end
                end
                ST_SP: begin
                    sp_q    <= rf_rdata;
                    ptr_q   <= save_q ? rf_rdata : rf_rdata + frame_w;
                    state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (!slot_any) begin
                        state_q <= ST_SPWR;
                    end else if (mem_ready) begin
                        pend_q <= pend_q & ~(NSLOT'(1) << slot_idx);
                        if (!cur_arg) ptr_q <= ptr_q - WORD_W'(WORD_BYTES);
                        if (!save_q) begin
                            load_reg_q <= slot_reg(slot_idx);
                            state_q    <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: state_q <= ST_XFER;
                ST_SPWR: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    sp_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rf_we && rf_waddr == SP_REG));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !mem_valid && !done);

    // R7
    load_lands_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready && !mem_we |=> rf_we && !mem_valid);

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !busy && !mem_valid && !done && !err);

endmodule

// File: tb/frame_seq_test.sv
`timescale 1ns/1ps
module frame_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_save = 1'b0, op_ext = 1'b0;
    logic [2:0]  link_mask = '0, extra_cnt = '0;
    logic [3:0]  arg_code = '0, frame_lo = '0, frame_hi = '0;
    logic        busy, done, err;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    frame_seq uut (
        .clk(clk), .rst(rst), .start(start), .op_save(op_save), .op_ext(op_ext),
        .link_mask(link_mask), .extra_cnt(extra_cnt), .arg_code(arg_code),
        .frame_lo(frame_lo), .frame_hi(frame_hi), .busy(busy), .done(done), .err(err),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // register file and memory models
    logic [31:0] rf [0:31];
    logic [31:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [4:0]  tb_waddr = '0;
    logic [31:0] tb_wdata = '0;
    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        else if (tb_we) rf[tb_waddr] <= tb_wdata;
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    bit stall_mode = 1'b0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= stall_mode ? ((cyc % 3) == 1) : 1'b1;
    end

    // scoreboard
    typedef struct { logic we; logic [31:0] addr; logic [31:0] data; } xfer_t;
    typedef struct { int r; logic [31:0] val; } rchk_t;
    xfer_t expq[$];
    rchk_t restq[$];

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;

    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            mon_checks++;
            if (expq.size() == 0) begin
                mon_errors++;
                $display("FAIL R4/R6 unexpected transfer addr=%h we=%0b expected none", mem_addr, mem_we);
            end else begin
                xfer_t e;
                e = expq.pop_front();
                if (e.we !== mem_we || e.addr !== mem_addr || (e.we && e.data !== mem_wdata)) begin
                    mon_errors++;
                    $display("FAIL R3/R4/R6 transfer we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                             mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tb_set(input int r, input logic [31:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_waddr = 5'(r); tb_wdata = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic int in_cnt(input logic [3:0] c);
        if (c == 4'd14) return 4;
        if (c == 4'd12 || c == 4'd13) return 3;
        if (c >= 4'd8 && c <= 4'd10) return 2;
        if (c >= 4'd4 && c <= 4'd7) return 1;
        return 0;
    endfunction

    function automatic int st_cnt(input logic [3:0] c);
        if (c == 4'd11) return 4;
        if (c == 4'd3 || c == 4'd7) return 3;
        if (c == 4'd2 || c == 4'd6 || c == 4'd10) return 2;
        if (c == 4'd1 || c == 4'd5 || c == 4'd9 || c == 4'd13) return 1;
        return 0;
    endfunction

    task automatic run_op(input bit sv, input bit ex, input logic [2:0] rm, input logic [2:0] xc,
                          input logic [3:0] ac, input logic [3:0] fh, input logic [3:0] fl,
                          input bit poke, input string sp_req);
        logic [31:0] sp, ptr, fr, exp_sp;
        int nin, nst, xe;
        int regs[$];
        bit bad, seen_done, seen_err;
        sp  = rf[29];
        bad = ex && (ac == 4'd15);
        fr  = ex ? (((32'(fh) << 4) | 32'(fl)) * 8) : ((fl == 0) ? 32'd128 : 32'(fl) * 8);
        nin = ex ? in_cnt(ac) : 0;
        nst = ex ? st_cnt(ac) : 0;
        xe  = ex ? int'(xc) : 0;
        restq.delete();
        if (!bad) begin
            if (sv) for (int i = 0; i < nin; i++) expq.push_back('{1'b1, sp + 32'(4 * i), rf[4 + i]});
            if (rm[2]) regs.push_back(31);
            if (xe == 7) regs.push_back(30);
            for (int r = 23; r >= 18; r--) if (r - 17 <= xe) regs.push_back(r);
            if (rm[0]) regs.push_back(17);
            if (rm[1]) regs.push_back(16);
            for (int k = 0; k < nst; k++) regs.push_back(7 - k);
            ptr = sv ? sp : sp + fr;
            foreach (regs[q]) begin
                ptr = ptr - 4;
                if (sv) expq.push_back('{1'b1, ptr, rf[regs[q]]});
                else begin
                    expq.push_back('{1'b0, ptr, 32'h0});
                    restq.push_back('{regs[q], mem[ptr[9:2]]});
                end
            end
            exp_sp = sv ? sp - fr : sp + fr;
        end else exp_sp = sp;

        @(negedge clk);
        start = 1'b1; op_save = sv; op_ext = ex; link_mask = rm; extra_cnt = xc;
        arg_code = ac; frame_hi = fh; frame_lo = fl;
        @(negedge clk);
        start = 1'b0;
        seen_done = 1'b0; seen_err = 1'b0;
        for (int k = 0; k < 400 && !seen_done && !seen_err; k++) begin
            if (k == 0 && !bad) check(busy === 1'b1, "R10 busy after start", 32'(busy), 32'd1);
            if (done) seen_done = 1'b1;
            if (err)  seen_err  = 1'b1;
            if (poke && k == 2) begin start = 1'b1; op_save = !sv; link_mask = 3'b000; end
            if (poke && k == 3) begin start = 1'b0; op_save = sv; link_mask = rm; end
            if (!seen_done && !seen_err) @(negedge clk);
        end
        if (bad) begin
            check(seen_err, "R8 err on code 15", 32'(seen_err), 32'd1);
            check(!seen_done, "R8 no done on code 15", 32'(seen_done), 32'd0);
            @(negedge clk);
            check(err === 1'b0, "R8 err one cycle", 32'(err), 32'd0);
        end else begin
            check(seen_done, "R10 done seen", 32'(seen_done), 32'd1);
            check(busy === 1'b0, "R10 idle at done", 32'(busy), 32'd0);
            @(negedge clk);
            check(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
        end
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R4/R6 all transfers issued", 32'(expq.size()), 32'd0);
        expq.delete();
        check(rf[29] === exp_sp, sp_req, rf[29], exp_sp);
        foreach (restq[q])
            check(rf[restq[q].r] === restq[q].val, "R7 restored value", rf[restq[q].r], restq[q].val);
    endtask

    task automatic clobber();
        for (int r = 4; r <= 7; r++) tb_set(r, 32'hDEAD_0000 | 32'(r));
        for (int r = 16; r <= 23; r++) tb_set(r, 32'hDEAD_0000 | 32'(r));
        tb_set(30, 32'hDEAD_001E);
        tb_set(31, 32'hDEAD_001F);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11 idle after reset", {29'd0, busy, done, err}, 32'd0);
        check(mem_valid === 1'b0 && rf_we === 1'b0, "R11 no request after reset", {30'd0, mem_valid, rf_we}, 32'd0);
        for (int r = 0; r < 32; r++) tb_set(r, 32'h8000_0000 ^ (32'(r) * 32'h0101_0101));

        // short form: frame 0 -> 128, prefix fields ignored (R1, R8)
        tb_set(29, 32'h300);
        run_op(1'b1, 1'b0, 3'b111, 3'd5, 4'd15, 4'd0, 4'd0, 1'b0, "R1 R5 short save sp");
        clobber();
        run_op(1'b0, 1'b0, 3'b111, 3'd0, 4'd0, 4'd0, 4'd0, 1'b0, "R7 short restore sp");

        // full list, code 14: four args, r30 first among extras, stalled bus (R2 R3 R4 R12)
        for (int r = 0; r < 32; r++) if (r != 29) tb_set(r, 32'h8000_0000 ^ (32'(r) * 32'h0101_0101));
        tb_set(29, 32'h300);
        stall_mode = 1'b1;
        run_op(1'b1, 1'b1, 3'b101, 3'd7, 4'd14, 4'd1, 4'd2, 1'b0, "R5 ext save sp");
        clobber();
        run_op(1'b0, 1'b1, 3'b101, 3'd7, 4'd14, 4'd1, 4'd2, 1'b0, "R7 ext restore sp");
        for (int r = 4; r <= 7; r++)
            check(rf[r] === (32'hDEAD_0000 | 32'(r)), "R6 args not reloaded", rf[r], 32'hDEAD_0000 | 32'(r));
        stall_mode = 1'b0;

        // code 11: four statics, second start while busy ignored (R2 R9)
        for (int r = 0; r < 32; r++) if (r != 29) tb_set(r, 32'h1234_0000 + 32'(r));
        tb_set(29, 32'h300);
        run_op(1'b1, 1'b1, 3'b010, 3'd3, 4'd11, 4'd0, 4'd5, 1'b1, "R9 R1 save sp once");
        clobber();
        run_op(1'b0, 1'b1, 3'b010, 3'd3, 4'd11, 4'd0, 4'd5, 1'b1, "R9 restore sp once");

        // code 6: one arg and two statics, zero extended frame (R1 R2)
        tb_set(29, 32'h300);
        stall_mode = 1'b1;
        run_op(1'b1, 1'b1, 3'b000, 3'd0, 4'd6, 4'd0, 4'd0, 1'b0, "R1 zero frame save sp");
        clobber();
        run_op(1'b0, 1'b1, 3'b000, 3'd0, 4'd6, 4'd0, 4'd0, 1'b0, "R1 zero frame restore sp");
        check(rf[4] === 32'hDEAD_0004, "R6 arg r4 kept", rf[4], 32'hDEAD_0004);
        stall_mode = 1'b0;

        // empty list still finishes (R10)
        tb_set(29, 32'h300);
        run_op(1'b0, 1'b0, 3'b000, 3'd0, 4'd0, 4'd0, 4'd3, 1'b0, "R10 empty restore sp");

        // illegal code (R8)
        tb_set(29, 32'h300);
        run_op(1'b1, 1'b1, 3'b111, 3'd2, 4'd15, 4'd0, 4'd4, 1'b0, "R8 sp unchanged");

        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + mon_errors + 1, checks + mon_checks + 1);
        $finish;
    end
endmodule